// File: doc/BRIEF.md
# Programmable SMI Interval Timer Pair

This unit holds two independent countdown timers that ask the processor for a system-management interrupt (SMI). The fast timer covers intervals in the millisecond range and takes its delay from a 2-bit rate code. The slow timer covers intervals of several seconds and takes its period from its own 2-bit select code. Each timer runs only while its enable input is high.

An enabled timer samples its code and counts the matching number of clock cycles. When that count runs out, the timer sets its own sticky status bit and the unit emits a one-cycle SMI request. If the enable is still high at that point, the timer reloads from the code as it stands in that cycle and keeps running. Software clears a status bit by writing 1 to it. All delays come from the `CLK_HZ` parameter, so the 1.5 ms case is exact whenever `CLK_HZ` is a multiple of 2000.

The surrounding power-management logic decodes its configuration registers and drives the code and enable inputs from them. In that register space, the fast timer's rate code is bits 7:6 of one 16-bit word and the slow timer's select code is bits 1:0 of another. The SMI handler reads `sts` and clears it through `sts_w1c`.

Top module: `smi_timer_pair`

## Requirements
- R1: After reset, `sts` is 2'b00 and `smi_req` is 0.
- R2: For a `sw_rate` code c, the fast timer's interval is 1.5 ms when c = 0 and 8·2^c ms (16, 32 or 64 ms) when c = 1, 2 or 3. The first expiry comes exactly that many cycles after the first clock edge that samples `sw_en` high.
- R3: For an `lp_sel` code c, the slow timer's period is 8·2^(3−c) s, which is 64, 32, 16 or 8 s for codes 0 to 3. The first expiry is timed the same way as in R2.
- R4: At expiry, a timer whose enable is still high reloads from its code as sampled in that cycle, so expiries repeat at that interval.
- R5: Driving a timer's enable low cancels its pending expiry. Raising the enable again starts a full new interval.
- R6: Expiry of the fast timer sets `sts[0]` and expiry of the slow timer sets `sts[1]`. Neither expiry changes the other bit, and a set bit stays set until it is cleared.
- R7: A 1 on `sts_w1c[i]` clears `sts[i]` at the next edge, while a 0 leaves it unchanged. If an expiry for bit i falls in the same cycle, the set wins.
- R8: Each expiry cycle gives `smi_req` high for exactly one cycle, appearing together with the status bit. When both timers expire in the same cycle, the unit gives a single pulse and sets both status bits.
- R9: A change of a timer's code while that timer is counting does not alter the interval already in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at `CLK_HZ` |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_en | input | 1 | Fast timer enable |
| sw_rate | input | 2 | Fast timer rate code |
| lp_en | input | 1 | Slow timer enable |
| lp_sel | input | 2 | Slow timer period code |
| sts_w1c | input | 2 | Write-one-to-clear strobes for `sts` |
| sts | output | 2 | Sticky expiry status: bit 0 for the fast timer, bit 1 for the slow timer |
| smi_req | output | 1 | One-cycle SMI request pulse |

## Verification
On every cycle, the embedded assertions check the following:
- A disabled timer clears its state.
- An expiry only happens when the timer was enabled on the previous cycle.
- Status bits stay set until cleared, and a clear without a competing set takes effect.
- Every SMI pulse lasts one cycle and has a status bit behind it.
- No pulse follows a cycle in which both timers were off.

The exact cycle count of each code's interval, the reload from a freshly sampled code, the cancel-and-restart behaviour and the coincident expiry of both timers depend on a sequence of stimulus. Only the bench's directed scenarios can show these.

// File: rtl/smi_timer_pkg.sv
package smi_timer_pkg;

    typedef enum logic {
        TMR_FAST = 1'b0,
        TMR_SLOW = 1'b1
    } tmr_kind_e;

    // Interval in clock cycles for a given timer kind and 2-bit code.
    function automatic longint interval_cycles(tmr_kind_e kind, int code, longint hz);
        longint half_ms;
        longint result;
        half_ms = hz / 2000;
        if (kind == TMR_FAST) begin
            if (code == 0) result = 3 * half_ms;             // 1.5 ms
            else           result = (half_ms * 16) << code;  // 8 * 2^code ms
        end else begin
            result = (hz * 8) << (3 - code);                 // 8 * 2^(3-code) s
        end
        return result;
    endfunction

    typedef struct packed {
        logic [1:0] bits;
    } sts_state_t;

    typedef struct packed {
        logic smi;
    } top_state_t;

endpackage

// File: rtl/smi_delay_decode.sv
module smi_delay_decode
    import smi_timer_pkg::*;
#(
    parameter tmr_kind_e KIND   = TMR_FAST,
    parameter longint    CLK_HZ = 24_000_000,
    parameter int        CNT_W  = 32
) (
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] dly
);

    localparam int NUM_CODES = 4;

    logic [CNT_W-1:0] table_w [NUM_CODES];

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_entry
        localparam longint CYC = interval_cycles(KIND, i, CLK_HZ);
        assign table_w[i] = CNT_W'(CYC);
    end

    always_comb begin
        dly = table_w[code];
    end

endmodule

// File: rtl/smi_interval_timer.sv
module smi_interval_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] dly,
    output logic             hit
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (!en) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (!st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.cnt   = dly - CNT_W'(1);
        end else if (st_q.cnt == '0) begin
            hit      = 1'b1;
            st_d.cnt = dly - CNT_W'(1);
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a disabled timer drops any pending interval
    p_off_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!st_q.armed && st_q.cnt == '0));

    // R5: expiry only after the timer was enabled on the previous cycle
    p_hit_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(en));

    // R2: a running counter never wraps above the loaded interval
    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && en && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)) || !$past(en));

endmodule

// File: rtl/smi_status_reg.sv
module smi_status_reg
    import smi_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] set,
    input  logic [1:0] w1c,
    output logic [1:0] sts
);

    sts_state_t s_d, s_q;

    always_comb begin
        s_d.bits = (s_q.bits & ~w1c) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sts = s_q.bits;

    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R6: a set bit holds until written with 1
        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.bits[i] && !w1c[i]) |=> s_q.bits[i]);
        // R7: a clear without a competing set takes effect
        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (w1c[i] && !set[i]) |=> !s_q.bits[i]);
    end

endmodule

// File: rtl/smi_timer_pair.sv
module smi_timer_pair
    import smi_timer_pkg::*;
#(
    parameter longint CLK_HZ = 24_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_en,
    input  logic [1:0] sw_rate,
    input  logic       lp_en,
    input  logic [1:0] lp_sel,
    input  logic [1:0] sts_w1c,
    output logic [1:0] sts,
    output logic       smi_req
);

    localparam longint MAX_CYC = interval_cycles(TMR_SLOW, 0, CLK_HZ);
    localparam int     CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] sw_dly, lp_dly;
    logic             sw_hit, lp_hit;

    smi_delay_decode #(.KIND(TMR_FAST), .CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_sw_dec (
        .code (sw_rate),
        .dly  (sw_dly)
    );

    smi_delay_decode #(.KIND(TMR_SLOW), .CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_lp_dec (
        .code (lp_sel),
        .dly  (lp_dly)
    );

    smi_interval_timer #(.CNT_W(CNT_W)) u_sw_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sw_en),
        .dly   (sw_dly),
        .hit   (sw_hit)
    );

    smi_interval_timer #(.CNT_W(CNT_W)) u_lp_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (lp_en),
        .dly   (lp_dly),
        .hit   (lp_hit)
    );

    smi_status_reg u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({lp_hit, sw_hit}),
        .w1c   (sts_w1c),
        .sts   (sts)
    );

    top_state_t t_d, t_q;

    always_comb begin
        t_d.smi = sw_hit | lp_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign smi_req = t_q.smi;

    // R8: every request is a single-cycle pulse
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |=> !smi_req);

    // R6: a request always comes with a status bit set
    p_pulse_has_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> (sts != 2'b00));

    // R8: no request follows a cycle with both timers off
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en && !lp_en) |=> !smi_req);

endmodule

// File: tb/smi_timer_pair_test.sv
`timescale 1ns/100ps
module smi_timer_pair_test;

    localparam longint HZ = 2000;   // one cycle per half millisecond

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_en = 1'b0;
    logic [1:0] sw_rate = 2'd0;
    logic       lp_en = 1'b0;
    logic [1:0] lp_sel = 2'd0;
    logic [1:0] sts_w1c = 2'd0;
    logic [1:0] sts;
    logic       smi_req;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    smi_timer_pair #(.CLK_HZ(HZ)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_en   (sw_en),
        .sw_rate (sw_rate),
        .lp_en   (lp_en),
        .lp_sel  (lp_sel),
        .sts_w1c (sts_w1c),
        .sts     (sts),
        .smi_req (smi_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (smi_req) seen++;
        end
        chk(req, "pulses during interval", seen, 0);
    endtask

    task automatic expect_pulse(input string req, input int exp_sts);
        @(negedge clk);
        chk(req, "smi_req at expiry", int'(smi_req), 1);
        chk(req, "sts at expiry", int'(sts), exp_sts);
    endtask

    task automatic clear_sts();
        sts_w1c = 2'b11;
        @(negedge clk);
        sts_w1c = 2'b00;
    endtask

    function automatic int fast_cyc(input int code);
        return (code == 0) ? 3 : (16 << code);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "sts after reset", int'(sts), 0);
        chk("R1", "smi_req after reset", int'(smi_req), 0);
    endtask

    // R2, R4: first interval and reload for one fast code
    task automatic t_fast(input int code);
        int d = fast_cyc(code);
        sw_rate = code[1:0];
        sw_en   = 1'b1;
        wait_quiet(d, "R2");
        expect_pulse("R2", 1);
        wait_quiet(d - 1, "R4");
        expect_pulse("R4", 1);
        sw_en = 1'b0;
        clear_sts();
    endtask

    // R9 then R4: code change mid-interval affects only the next interval
    task automatic t_fresh();
        sw_rate = 2'd0;
        sw_en   = 1'b1;
        @(negedge clk);
        sw_rate = 2'd1;
        wait_quiet(2, "R9");
        expect_pulse("R9", 1);
        wait_quiet(31, "R4");
        expect_pulse("R4", 1);
        sw_en = 1'b0;
        clear_sts();
    endtask

    // R5: cancel and restart
    task automatic t_cancel();
        sw_rate = 2'd1;
        sw_en   = 1'b1;
        wait_quiet(10, "R5");
        sw_en = 1'b0;
        wait_quiet(50, "R5");
        chk("R5", "sts after cancel", int'(sts), 0);
        sw_en = 1'b1;
        wait_quiet(32, "R5");
        expect_pulse("R5", 1);
        sw_en = 1'b0;
        clear_sts();
    endtask

    // R7: write-one-to-clear and set priority
    task automatic t_w1c();
        sw_rate = 2'd0;
        sw_en   = 1'b1;
        wait_quiet(3, "R7");
        expect_pulse("R7", 1);
        sw_en   = 1'b0;
        sts_w1c = 2'b10;
        @(negedge clk);
        chk("R7", "sts after w1c on other bit", int'(sts), 1);
        sts_w1c = 2'b00;
        @(negedge clk);
        chk("R7", "sts after zero write", int'(sts), 1);
        sts_w1c = 2'b01;
        @(negedge clk);
        sts_w1c = 2'b00;
        chk("R7", "sts after w1c", int'(sts), 0);
        sw_en = 1'b1;
        repeat (3) @(negedge clk);
        sts_w1c = 2'b01;
        @(negedge clk);
        sts_w1c = 2'b00;
        sw_en   = 1'b0;
        chk("R7", "smi_req with clear at expiry", int'(smi_req), 1);
        chk("R7", "set wins over clear", int'(sts), 1);
        @(negedge clk);
        chk("R7", "sts held after set-wins", int'(sts), 1);
        clear_sts();
    endtask

    // R3, R6, R8: slow timer alone and coincident with fast timer
    task automatic t_slow();
        int pulses = 0;
        sw_rate = 2'd3;
        lp_sel  = 2'd3;
        sw_en   = 1'b1;
        lp_en   = 1'b1;
        for (int i = 0; i < 16000; i++) begin
            @(negedge clk);
            if (smi_req) pulses++;
        end
        chk("R8", "fast pulses before coincidence", pulses, 124);
        chk("R6", "slow bit before its expiry", int'(sts[1]), 0);
        expect_pulse("R8", 3);
        @(negedge clk);
        chk("R8", "single pulse on coincident expiry", int'(smi_req), 0);
        sw_en = 1'b0;
        lp_en = 1'b0;
        clear_sts();
        lp_sel = 2'd2;
        lp_en  = 1'b1;
        wait_quiet(32000, "R3");
        expect_pulse("R3", 2);
        chk("R6", "fast bit untouched by slow expiry", int'(sts[0]), 0);
        lp_en = 1'b0;
        clear_sts();
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        for (int c = 0; c < 4; c++) t_fast(c);
        t_fresh();
        t_cancel();
        t_w1c();
        t_slow();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule